// File: doc/BRIEF.md
# SMBus Clock-Stuck and Bus-Idle Timeout Monitor

This block sits beside an SMBus slave engine and watches the two bus lines, SCL and SDA. Both arrive already synchronized to the system clock. It detects two conditions. The first is a clock line that a device holds low for too long. The second is a bus on which both lines have stayed high long enough to count as free.

Either condition produces a single-cycle pulse that returns the slave protocol state machine to idle, so it is ready for a new transfer. A stuck clock also sets a sticky interrupt flag, which software clears. A free bus is reported on a level output.

Stuck-clock detection uses a reload timer. The timer is held at its reload value while SCL is high and counts only while SCL is low. Its overflow is the timeout event. A separate counter measures how long the bus has been idle. Stuck-clock detection is on after reset and after every wake-up from low power. Software can switch it off.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset, `lowToFlag`, `busFree` and `slaveRst` are 0, and stuck-clock detection is enabled.
- R2: The low timer advances only on clock edges that sample `sclIn` low. Any edge that samples `sclIn` high returns it to the reload value. Two low stretches of `LOW_TICKS-1` cycles each, with SCL high between them, raise no timeout.
- R3: When detection is enabled and `sclIn` is sampled low on `LOW_TICKS` consecutive edges (`LOW_TICKS` = `CLK_KHZ*LOW_TIMEOUT_MS`, which is 25 ms by default), `lowToFlag` and `slaveRst` are both 1 after that edge. `slaveRst` is 1 for exactly one cycle.
- R4: The timer reloads on overflow. If SCL stays low, another timeout pulse follows every `LOW_TICKS` cycles.
- R5: `lowToFlag` stays set until `flagClear` is sampled high, and then it reads 0. If a clear and an overflow occur on the same edge, the flag stays 1.
- R6: A write with `lowEnWrite`=1 and `lowEnValue`=0 disables stuck-clock detection. SCL can then stay low for any length of time without raising the flag or a pulse.
- R7: A `wakeUp` pulse re-enables stuck-clock detection.
- R8: When `freeEn` is 1, `busFree` and a one-cycle `slaveRst` appear after the edge that samples SCL and SDA both high for the (`FREE_TICKS`+1)-th consecutive time. `FREE_TICKS` is 1250 by default. `busFree` then stays 1.
- R9: An edge that samples either line low clears `busFree` and restarts the idle count from zero.
- R10: While `freeEn` is 0, `busFree` stays 0 and an idle bus causes no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous to `clk` |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level |
| lowEnWrite | input | 1 | Strobe that loads `lowEnValue` into the stuck-clock enable |
| lowEnValue | input | 1 | New value of the stuck-clock enable |
| wakeUp | input | 1 | Wake-up event from low power; re-enables stuck-clock detection |
| freeEn | input | 1 | Enables bus-free detection |
| flagClear | input | 1 | Software clear of the interrupt flag |
| slaveRst | output | 1 | One-cycle reset pulse to the slave state machine |
| lowToFlag | output | 1 | Sticky stuck-clock interrupt flag |
| busFree | output | 1 | Bus idle long enough to be declared free |

## Verification
The bench builds the monitor with `CLK_KHZ`=4 and `LOW_TIMEOUT_MS`=5, which gives a 20-cycle low timeout, and with `FREE_TICKS`=12. At these values every edge case fits into a few hundred cycles. These cases are the last edge before an overflow, a repeated overflow on a clock that stays stuck, a clear that arrives on the same edge as an overflow, and the idle-count restart. The default values would need more than half a million cycles for each low timeout.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic lowRun;     // advance low timer this edge
    logic lowReload;  // return low timer to reload value
    logic freeRun;    // advance idle counter this edge
  } tmrStrobe_t;

  // datapath -> control terminal counts
  typedef struct packed {
    logic lowTerm;    // low timer at its last count before overflow
    logic freeTerm;   // idle counter reached its limit
  } tmrStatus_t;
endpackage

// File: rtl/smbto_timers.sv
module smbto_timers
  import smbto_pkg::*;
#(
  parameter int LOW_TICKS  = 625000,
  parameter int FREE_TICKS = 1250
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strb,
  output tmrStatus_t stat
);
  localparam int LW = (LOW_TICKS > 2) ? $clog2(LOW_TICKS) : 1;
  localparam int FW = $clog2(FREE_TICKS + 1);
  localparam logic [LW-1:0] LOW_LAST  = LW'(LOW_TICKS - 1);
  localparam logic [FW-1:0] FREE_LAST = FW'(FREE_TICKS);

  logic [LW-1:0] lowCnt;
  logic [FW-1:0] freeCnt;

  always_ff @(posedge clk) begin
    if (!rstN)               lowCnt <= '0;
    else if (strb.lowReload) lowCnt <= '0;
    else if (strb.lowRun)    lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   freeCnt <= '0;
    else if (!strb.freeRun)      freeCnt <= '0;
    else if (freeCnt != FREE_LAST) freeCnt <= freeCnt + 1'b1;
  end

  always_comb begin
    stat.lowTerm  = (lowCnt == LOW_LAST);
    stat.freeTerm = (freeCnt == FREE_LAST);
  end

  // R2: timer sits at reload whenever it was not allowed to run
  p_low_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lowRun |=> (lowCnt == '0));

  // R9: idle count restarts from zero once idle is broken
  p_free_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.freeRun |=> (freeCnt == '0));
endmodule

// File: rtl/smbto_ctrl.sv
module smbto_ctrl
  import smbto_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       lowEnWrite,
  input  logic       lowEnValue,
  input  logic       wakeUp,
  input  logic       freeEn,
  input  logic       flagClear,
  input  tmrStatus_t stat,
  output tmrStrobe_t strb,
  output logic       slaveRst,
  output logic       lowToFlag,
  output logic       busFree
);
  logic lowEnR;
  logic lowRun;
  logic lowEvt;
  logic idleRun;
  logic freeEvt;

  always_ff @(posedge clk) begin
    if (!rstN)           lowEnR <= 1'b1;
    else if (wakeUp)     lowEnR <= 1'b1;
    else if (lowEnWrite) lowEnR <= lowEnValue;
  end

  always_comb begin
    lowRun         = lowEnR & ~sclIn;
    lowEvt         = lowRun & stat.lowTerm;
    idleRun        = freeEn & sclIn & sdaIn;
    freeEvt        = idleRun & stat.freeTerm & ~busFree;
    strb.lowRun    = lowRun;
    strb.lowReload = ~lowRun | lowEvt;
    strb.freeRun   = idleRun;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slaveRst  <= 1'b0;
      lowToFlag <= 1'b0;
      busFree   <= 1'b0;
    end else begin
      slaveRst <= lowEvt | freeEvt;
      if (lowEvt)         lowToFlag <= 1'b1;
      else if (flagClear) lowToFlag <= 1'b0;
      if (!idleRun)       busFree <= 1'b0;
      else if (freeEvt)   busFree <= 1'b1;
    end
  end

  // R3: slave reset is a single-cycle pulse
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    slaveRst |=> !slaveRst);

  // R5: overflow wins over a simultaneous clear
  p_flag_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lowRun && stat.lowTerm) |=> lowToFlag);

  // R5: clear without overflow drops the flag
  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !(lowRun && stat.lowTerm)) |=> !lowToFlag);

  // R9: a low line ends the free state on the next edge
  p_free_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sclIn || !sdaIn) |=> !busFree);

  // R8: entering the free state is accompanied by the reset pulse
  p_free_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busFree) |-> slaveRst);

  // R10: no free state while disabled
  p_free_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    !freeEn |=> !busFree);
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon
  import smbto_pkg::*;
#(
  parameter int CLK_KHZ        = 25000,
  parameter int LOW_TIMEOUT_MS = 25,
  parameter int FREE_TICKS     = 1250
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic lowEnWrite,
  input  logic lowEnValue,
  input  logic wakeUp,
  input  logic freeEn,
  input  logic flagClear,
  output logic slaveRst,
  output logic lowToFlag,
  output logic busFree
);
  localparam int LOW_TICKS = CLK_KHZ * LOW_TIMEOUT_MS;

  tmrStrobe_t strb;
  tmrStatus_t stat;

  smbto_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .lowEnWrite(lowEnWrite), .lowEnValue(lowEnValue), .wakeUp(wakeUp),
    .freeEn(freeEn), .flagClear(flagClear), .stat(stat), .strb(strb),
    .slaveRst(slaveRst), .lowToFlag(lowToFlag), .busFree(busFree)
  );

  smbto_timers #(.LOW_TICKS(LOW_TICKS), .FREE_TICKS(FREE_TICKS)) timers_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat)
  );

  // R1: nothing is reported in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!slaveRst && !lowToFlag && !busFree));
endmodule

// File: tb/smbus_timeout_mon_tb_top.sv
module smbus_timeout_mon_tb_top;
  localparam int LT = 20;   // 4 kHz * 5 ms
  localparam int FT = 12;

  logic clk = 1'b0;
  logic rstN, sclIn, sdaIn, lowEnWrite, lowEnValue, wakeUp, freeEn, flagClear;
  logic slaveRst, lowToFlag, busFree;
  int   nRun = 0, nFail = 0, pulseCnt = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  smbus_timeout_mon #(.CLK_KHZ(4), .LOW_TIMEOUT_MS(5), .FREE_TICKS(FT)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .lowEnWrite(lowEnWrite), .lowEnValue(lowEnValue), .wakeUp(wakeUp),
    .freeEn(freeEn), .flagClear(flagClear),
    .slaveRst(slaveRst), .lowToFlag(lowToFlag), .busFree(busFree)
  );

  always @(negedge clk) if (slaveRst === 1'b1) pulseCnt++;

  task automatic chk(string req, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkInt(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clearFlag();
    @(negedge clk) flagClear = 1'b1;
    @(negedge clk) flagClear = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0; sclIn = 1'b1; sdaIn = 1'b1; lowEnWrite = 1'b0; lowEnValue = 1'b0;
    wakeUp = 1'b0; freeEn = 1'b0; flagClear = 1'b0;
    edges(3);
    @(negedge clk) rstN = 1'b1;
    edges(1);
    chk("R1 flag", lowToFlag, 1'b0);
    chk("R1 busFree", busFree, 1'b0);
    chk("R1 slaveRst", slaveRst, 1'b0);
  endtask

  task automatic tNoCarry();  // R2
    int p0 = pulseCnt;
    @(negedge clk) sclIn = 1'b0;
    edges(LT - 1);
    @(negedge clk) sclIn = 1'b1;
    edges(3);
    @(negedge clk) sclIn = 1'b0;
    edges(LT - 1);
    chk("R2 flag", lowToFlag, 1'b0);
    chkInt("R2 pulses", pulseCnt - p0, 0);
    @(negedge clk) sclIn = 1'b1;
    edges(2);
  endtask

  task automatic tLowTimeout();  // R3, R4, R1 default enable
    @(negedge clk) sclIn = 1'b0;
    edges(LT - 1);
    chk("R3 flag before", lowToFlag, 1'b0);
    edges(1);
    chk("R3 flag", lowToFlag, 1'b1);
    chk("R3 pulse", slaveRst, 1'b1);
    edges(1);
    chk("R3 pulse width", slaveRst, 1'b0);
    edges(LT - 2);
    chk("R4 before repeat", slaveRst, 1'b0);
    edges(1);
    chk("R4 repeat pulse", slaveRst, 1'b1);
    @(negedge clk) sclIn = 1'b1;
    edges(2);
  endtask

  task automatic tFlag();  // R5
    chk("R5 sticky", lowToFlag, 1'b1);
    clearFlag();
    edges(1);
    chk("R5 cleared", lowToFlag, 1'b0);
    @(negedge clk) sclIn = 1'b0;
    edges(LT - 1);
    @(negedge clk) flagClear = 1'b1;
    edges(1);
    chk("R5 set wins", lowToFlag, 1'b1);
    @(negedge clk) begin flagClear = 1'b0; sclIn = 1'b1; end
    clearFlag();
    edges(1);
    chk("R5 cleared again", lowToFlag, 1'b0);
  endtask

  task automatic tDisable();  // R6
    int p0;
    @(negedge clk) begin lowEnWrite = 1'b1; lowEnValue = 1'b0; end
    @(negedge clk) begin lowEnWrite = 1'b0; sclIn = 1'b0; end
    p0 = pulseCnt;
    edges(3 * LT);
    chk("R6 flag", lowToFlag, 1'b0);
    chkInt("R6 pulses", pulseCnt - p0, 0);
    @(negedge clk) sclIn = 1'b1;
    edges(2);
  endtask

  task automatic tWake();  // R7
    @(negedge clk) wakeUp = 1'b1;
    @(negedge clk) begin wakeUp = 1'b0; sclIn = 1'b0; end
    edges(LT);
    chk("R7 flag", lowToFlag, 1'b1);
    @(negedge clk) sclIn = 1'b1;
    clearFlag();
    edges(2);
  endtask

  task automatic tFree();  // R8, R9
    @(negedge clk) freeEn = 1'b1;
    edges(FT);
    chk("R8 before", busFree, 1'b0);
    edges(1);
    chk("R8 busFree", busFree, 1'b1);
    chk("R8 pulse", slaveRst, 1'b1);
    edges(1);
    chk("R8 pulse width", slaveRst, 1'b0);
    chk("R8 held", busFree, 1'b1);
    @(negedge clk) sdaIn = 1'b0;
    edges(1);
    chk("R9 sda drop", busFree, 1'b0);
    @(negedge clk) sdaIn = 1'b1;
    edges(FT);
    chk("R9 restart", busFree, 1'b0);
    edges(1);
    chk("R9 free again", busFree, 1'b1);
    @(negedge clk) sclIn = 1'b0;
    edges(1);
    chk("R9 scl drop", busFree, 1'b0);
    @(negedge clk) sclIn = 1'b1;
  endtask

  task automatic tFreeOff();  // R10
    int p0;
    @(negedge clk) freeEn = 1'b0;
    p0 = pulseCnt;
    edges(3 * FT);
    chk("R10 busFree", busFree, 1'b0);
    chkInt("R10 pulses", pulseCnt - p0, 0);
  endtask

  initial begin
    tReset();
    tNoCarry();
    tLowTimeout();
    tFlag();
    tDisable();
    tWake();
    tFree();
    tFreeOff();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule